// File: doc/BRIEF.md
# Inter-Stage Twiddle Rotator for a 64x64 Inverse FFT

This block sits between the two stages of a 4096-point inverse FFT that has been split into a 64-point front transform and a 64-point back transform. The front stage delivers its results as a stream of complex samples, 32-bit signed real and imaginary parts, in a fixed index order. The block multiplies each sample by a complex twiddle factor. The factor depends on the sample's bin index k1 and column index n2. The block then streams the rotated sample on to the back stage. Each sample gets one complex multiply. The result is rounded and saturated back to 32 bits per component.

Both sides use a stream handshake with valid, ready and a frame-last flag. The block counts accepted samples to find each sample's position in the frame. From that position it forms the exponent (k1·n2) mod 4096. A quarter-wave cosine table supplies the Q15 twiddle components for that exponent. The multiply runs in a fixed four-stage pipeline. When the output is held by the receiver, the entire pipeline freezes.

Top module: `twiddle_rotator`

## Requirements
- R1: When out_valid is 1 and out_ready is 0, the output holds: out_valid, out_re, out_im and out_last keep their values on the next cycle. in_ready equals (not out_valid) or out_ready.
- R2: A sample accepted on a rising edge (in_valid and in_ready both 1) appears on the output 4 edges later, provided the pipeline does not stall. Samples leave in the order they arrived.
- R3: For the j-th sample accepted in a frame (j counting from 0), k1 = j mod 64 (the low 6 bits of j) and n2 = j / 64 (the high 6 bits). The twiddle exponent is e = (k1·n2) mod 4096.
- R4: The twiddle real part is round(32768·cos(2πe/4096)) and the imaginary part is round(32768·sin(2πe/4096)). Rounding goes to the nearest integer, with halves rounded away from zero. Each component is clamped to [-32767, 32767]. This is the inverse-direction factor e^{+j2πe/4096}.
- R5: For input a + jb and twiddle c + jd, the raw outputs are re = ac − bd and im = ad + bc. Each is rounded half up as floor((x + 2^14) / 2^15).
- R6: Each rounded component is saturated to [-2^31, 2^31−1].
- R7: out_last is 1 exactly on the output sample produced from an input sample that was accepted with in_last = 1.
- R8: After a sample is accepted with in_last = 1, the next accepted sample has j = 0. Without a last flag, j wraps from 4095 back to 0.
- R9: After reset, out_valid is 0, in_ready is 1, and the next accepted sample has j = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_re | input | 32 | Input real part, signed |
| in_im | input | 32 | Input imaginary part, signed |
| in_last | input | 1 | Last sample of the frame |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Receiver can accept a sample |
| out_re | output | 32 | Rotated real part, signed |
| out_im | output | 32 | Rotated imaginary part, signed |
| out_last | output | 1 | Last rotated sample of the frame |

## Verification
A rotated sample is due 4 rising edges after it is accepted, counting the accepting edge as the first. This assumes the output is not held. The latency check drops in_valid after the accepting edge and counts falling edges until out_valid rises. It expects out_valid on the fourth. All other results are matched in order against a queue that the bench fills at each accepting edge from its own index tracker and arithmetic model. Each output is compared on the falling edge before the edge that hands it off, so a stall only delays the comparison and never changes which value is expected. During a hold, the value seen on one falling edge is compared with the value seen on the next.

// File: rtl/tr_pkg.sv
package tr_pkg;
  localparam int DATA_W   = 32;
  localparam int TWID_W   = 16;
  localparam int LOG_N1   = 6;
  localparam int LOG_N2   = 6;
  localparam int PIPE_LAT = 4;

  typedef enum logic [1:0] {
    QUAD_0 = 2'd0,
    QUAD_1 = 2'd1,
    QUAD_2 = 2'd2,
    QUAD_3 = 2'd3
  } quad_e;
endpackage

// File: rtl/tr_index_gen.sv
module tr_index_gen #(
  parameter int LOG_N1 = 6,
  parameter int LOG_N2 = 6,
  localparam int LOG_N = LOG_N1 + LOG_N2,
  localparam int QLOG  = LOG_N - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            last,
  output logic [1:0]      quad,
  output logic [QLOG:0]   cos_addr,
  output logic [QLOG:0]   sin_addr
);
  localparam logic [QLOG:0] QSIZE = {1'b1, {QLOG{1'b0}}};

  logic [LOG_N-1:0] idx;
  logic [LOG_N-1:0] k1x, n2x, expo;

  // R3: low bits are the bin, high bits the column
  assign k1x  = {{LOG_N2{1'b0}}, idx[LOG_N1-1:0]};
  assign n2x  = {{LOG_N1{1'b0}}, idx[LOG_N-1:LOG_N1]};
  assign expo = k1x * n2x;

  assign quad     = expo[LOG_N-1:LOG_N-2];
  assign cos_addr = {1'b0, expo[QLOG-1:0]};
  assign sin_addr = QSIZE - {1'b0, expo[QLOG-1:0]};

  // R8 / R9: restart on reset or accepted last, natural wrap otherwise
  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (step) idx <= last ? '0 : idx + 1'b1;
  end

  a_r8_restart_after_last: assert property (@(posedge clk) disable iff (rst)
    (step && last) |=> (idx == '0));

  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && !last && (&idx)) |=> (idx == '0));

  a_r1_idx_frozen: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(idx));
endmodule

// File: rtl/tr_quarter_rom.sv
module tr_quarter_rom #(
  parameter int QLOG   = 10,
  parameter int TWID_W = 16,
  localparam int DEPTH = (1 << QLOG) + 1,
  localparam int FULL  = 4 << QLOG
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [QLOG:0]            addr_a,
  input  logic [QLOG:0]            addr_b,
  output logic signed [TWID_W-1:0] dout_a,
  output logic signed [TWID_W-1:0] dout_b
);
  localparam int  SCALE = 1 << (TWID_W - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic signed [TWID_W-1:0] mem [DEPTH];

  // R4: cos over the first quarter turn, rounded half away, clamped
  function automatic logic signed [TWID_W-1:0] cos_entry(input int m);
    real v;
    int  r;
    v = $itor(SCALE) * $cos(TWO_PI * $itor(m) / $itor(FULL));
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    if (r > SCALE - 1) r = SCALE - 1;
    return TWID_W'(r);
  endfunction

  initial begin
    for (int m = 0; m < DEPTH; m++) mem[m] = cos_entry(m);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      dout_a <= mem[addr_a];
      dout_b <= mem[addr_b];
    end
  end
endmodule

// File: rtl/tr_cmul.sv
module tr_cmul #(
  parameter int DATA_W = 32,
  parameter int TWID_W = 16,
  localparam int PW   = DATA_W + TWID_W,
  localparam int SW   = PW + 1,
  localparam int FRAC = TWID_W - 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     v_in,
  input  logic                     l_in,
  input  logic signed [DATA_W-1:0] a_re,
  input  logic signed [DATA_W-1:0] a_im,
  input  logic signed [TWID_W-1:0] t_re,
  input  logic signed [TWID_W-1:0] t_im,
  output logic                     v_out,
  output logic                     l_out,
  output logic signed [DATA_W-1:0] o_re,
  output logic signed [DATA_W-1:0] o_im
);
  localparam logic signed [SW-1:0] MAXV = {{(SW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);

  logic signed [PW-1:0] p_ac, p_bd, p_ad, p_bc;
  logic                 pv, pl;
  logic signed [SW-1:0] s_re, s_im;

  // R5 / R6: round half up then clamp to the data range
  function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [SW-1:0] x);
    logic signed [SW-1:0] r;
    r = (x + HALF) >>> FRAC;
    if (r > MAXV)      return MAXV[DATA_W-1:0];
    else if (r < MINV) return MINV[DATA_W-1:0];
    else               return r[DATA_W-1:0];
  endfunction

  assign s_re = SW'(p_ac) - SW'(p_bd);
  assign s_im = SW'(p_ad) + SW'(p_bc);

  always_ff @(posedge clk) begin
    if (rst) begin
      pv    <= 1'b0;
      v_out <= 1'b0;
    end else if (en) begin
      pv    <= v_in;
      v_out <= pv;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      p_ac  <= a_re * t_re;
      p_bd  <= a_im * t_im;
      p_ad  <= a_re * t_im;
      p_bc  <= a_im * t_re;
      pl    <= l_in;
      l_out <= pl;
      o_re  <= rnd_sat(s_re);
      o_im  <= rnd_sat(s_im);
    end
  end

  a_r1_cmul_freeze: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(pv) && $stable(v_out)));
endmodule

// File: rtl/twiddle_rotator.sv
module twiddle_rotator
  import tr_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int TW  = TWID_W,
  parameter int LN1 = LOG_N1,
  parameter int LN2 = LOG_N2,
  localparam int QLOG = LN1 + LN2 - 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic                 in_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 out_last
);
  logic adv, take;
  logic [1:0]    quad_c;
  logic [QLOG:0] cos_a, sin_a;

  // stage 1: table read alongside the data
  logic                 s1_v, s1_l;
  logic [1:0]           s1_q;
  logic signed [DW-1:0] s1_re, s1_im;
  logic signed [TW-1:0] rom_c, rom_s;

  // stage 2: quadrant-mapped twiddle
  logic                 s2_v, s2_l;
  logic signed [DW-1:0] s2_re, s2_im;
  logic signed [TW-1:0] s2_tr, s2_ti;

  // R1: one global advance, the whole pipeline stalls together
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign take     = in_valid && adv;

  tr_index_gen #(.LOG_N1(LN1), .LOG_N2(LN2)) u_idx (
    .clk(clk), .rst(rst), .step(take), .last(in_last),
    .quad(quad_c), .cos_addr(cos_a), .sin_addr(sin_a)
  );

  tr_quarter_rom #(.QLOG(QLOG), .TWID_W(TW)) u_rom (
    .clk(clk), .en(adv), .addr_a(cos_a), .addr_b(sin_a),
    .dout_a(rom_c), .dout_b(rom_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else if (adv) begin
      s1_v <= in_valid;
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_l  <= in_last;
      s1_q  <= quad_c;
      s1_re <= in_re;
      s1_im <= in_im;
      s2_l  <= s1_l;
      s2_re <= s1_re;
      s2_im <= s1_im;
      // R4: rebuild the full-turn factor from the quarter table
      case (quad_e'(s1_q))
        QUAD_0:  begin s2_tr <= rom_c;  s2_ti <= rom_s;  end
        QUAD_1:  begin s2_tr <= -rom_s; s2_ti <= rom_c;  end
        QUAD_2:  begin s2_tr <= -rom_c; s2_ti <= -rom_s; end
        default: begin s2_tr <= rom_s;  s2_ti <= -rom_c; end
      endcase
    end
  end

  tr_cmul #(.DATA_W(DW), .TWID_W(TW)) u_mul (
    .clk(clk), .rst(rst), .en(adv),
    .v_in(s2_v), .l_in(s2_l),
    .a_re(s2_re), .a_im(s2_im), .t_re(s2_tr), .t_im(s2_ti),
    .v_out(out_valid), .l_out(out_last), .o_re(out_re), .o_im(out_im)
  );

  localparam logic signed [TW-1:0] TMIN = {1'b1, {(TW-1){1'b0}}};

  a_r1_hold_output: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last)));

  a_r4_twiddle_range: assert property (@(posedge clk) disable iff (rst)
    s2_v |-> ((s2_tr != TMIN) && (s2_ti != TMIN)));

  a_r2_stall_freeze: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(s1_v) && $stable(s2_v)));
endmodule

// File: tb/twiddle_rotator_test.sv
`timescale 1ns/1ps
module twiddle_rotator_test;
  localparam int  NPT = 4096;
  localparam real PI2 = 6.283185307179586;
  localparam logic signed [31:0] SMAX = 32'h7FFFFFFF;
  localparam logic signed [31:0] SMIN = 32'h80000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic signed [31:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, out_last;
  logic signed [31:0] out_re, out_im;

  always #10 clk = ~clk;

  twiddle_rotator uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_last(out_last)
  );

  int tests = 0, fails = 0;
  int jtrk = 0;
  int sat_seen = 0;
  int bp_mode = 0;
  string tag = "R5";
  logic [64:0] expq [$];

  function automatic int rnd_away(input real v);
    int r;
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    if (r > 32767) r = 32767;
    if (r < -32767) r = -32767;
    return r;
  endfunction

  function automatic longint rs(input longint x);
    longint r;
    r = (x + 16384) >>> 15;
    if (r > 64'sd2147483647) r = 64'sd2147483647;
    if (r < -64'sd2147483648) r = -64'sd2147483648;
    return r;
  endfunction

  // R3/R4/R5/R6 model, written from the requirements
  function automatic logic [64:0] model(input int j, input logic signed [31:0] a,
                                        input logic signed [31:0] b, input logic l);
    int e, c, d;
    longint x, y;
    e = ((j % 64) * (j / 64)) % NPT;
    c = rnd_away(32768.0 * $cos(PI2 * e / NPT));
    d = rnd_away(32768.0 * $sin(PI2 * e / NPT));
    x = rs(longint'(a) * c - longint'(b) * d);
    y = rs(longint'(a) * d + longint'(b) * c);
    return {l, x[31:0], y[31:0]};
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // output-side backpressure driver
  initial begin
    logic [7:0] lf = 8'hA5;
    forever begin
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = (bp_mode == 0) ? 1'b1 : lf[0] | lf[2];
    end
  end

  // monitor: compare on the falling edge before each handoff
  logic pstall = 1'b0;
  logic signed [31:0] pre, pim;
  logic pl;
  always @(negedge clk) begin
    if (!rst) begin
      if (pstall) begin
        check("R1 hold valid", out_valid, 1);
        check("R1 hold re", out_re, pre);
        check("R1 hold im", out_im, pim);
        check("R1 hold last", out_last, pl);
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check("R2 unexpected output", 1, 0);
        else begin
          logic [64:0] ex;
          ex = expq.pop_front();
          check({tag, " re"}, out_re, $signed(ex[63:32]));
          check({tag, " im"}, out_im, $signed(ex[31:0]));
          check("R7 last", out_last, ex[64]);
          if (out_re == SMAX || out_re == SMIN || out_im == SMAX || out_im == SMIN) sat_seen++;
        end
      end
      pstall = out_valid && !out_ready;
      pre = out_re; pim = out_im; pl = out_last;
    end
  end

  // one beat; entered and left just after a rising edge, in_valid stays high
  task automatic send(input logic signed [31:0] a, input logic signed [31:0] b, input logic l);
    in_valid = 1'b1; in_re = a; in_im = b; in_last = l;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    expq.push_back(model(jtrk, a, b, l));
    jtrk = l ? 0 : (jtrk + 1) % NPT;
    @(posedge clk); #1;
  endtask

  task automatic drain();
    in_valid = 1'b0; in_last = 1'b0;
    for (int i = 0; i < 2000 && expq.size() != 0; i++) @(posedge clk);
    #1;
    check("R2 drain", expq.size(), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 out_valid after reset", out_valid, 0);
    check("R9 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;
  endtask

  task automatic t_latency();
    int n = 0;
    tag = "R9 first sample j=0";
    send(32'sd1000000, -32'sd77, 1'b1);
    in_valid = 1'b0; in_last = 1'b0;
    do begin @(negedge clk); n++; end while (!out_valid && n < 20);
    check("R2 latency", n, 4);
    drain();
  endtask

  task automatic t_frame(input int seed, input int bp, input string t);
    bp_mode = bp; tag = t;
    for (int j = 0; j < NPT; j++) begin
      int unsigned h;
      h = (j + seed) * 32'd2654435761;
      send($signed(h), $signed(h ^ 32'h5A5AC3C3), j == NPT - 1);
    end
    drain();
    bp_mode = 0;
  endtask

  task automatic t_early_last();
    tag = "R8 restart after early last";
    for (int j = 0; j < 100; j++) send(32'sd3 * j + 32'sd12345, 32'sd40000 - j, j == 99);
    for (int j = 0; j < 200; j++) send(32'sd99999 - j, 32'sd7 * j, 1'b0);
    drain();
    tag = "R8 close frame";
    send(32'sd1, 32'sd1, 1'b1);
    drain();
  endtask

  task automatic t_saturate();
    sat_seen = 0;
    tag = "R6 saturation";
    for (int j = 0; j < 2200; j++) send(SMAX, SMIN, j == 2199);
    drain();
    check("R6 saturated outputs observed", sat_seen > 0, 1);
  endtask

  task automatic t_round();
    tag = "R5 rounding at unit twiddle";
    send(32'sd1, -32'sd1, 1'b0);
    send(-32'sd3, 32'sd2, 1'b1);
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_latency();
    t_round();
    t_frame(7, 0, "R3/R4/R5 full frame");
    t_frame(913, 1, "R1 frame under backpressure");
    t_early_last();
    t_saturate();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule